// File: doc/BRIEF.md
# Sequenced Register-plus-Immediate Adder Datapath

This block is a small, non-pipelined processor datapath. It runs one instruction at a time through a fixed sequence of single-cycle steps. Each instruction follows the same order: drive the instruction address, capture the instruction word, decode it, advance the address, read the source register onto the A bus, put the immediate on the B bus, rotate it, add, and write back. Only one operation, add-immediate, is carried out. Any other opcode is fetched, decoded and stepped past.

A sixteen-entry register bank holds the operands. Its last entry mirrors the next-instruction address and works as the program counter. A dedicated incrementer produces each sequential address. A barrel rotator sits in the second operand path. The block talks to memory only through a one-way address output, a fetch strobe and an instruction data input. A write to the last register redirects the fetch stream, and this is also how register contents become visible outside the block.

Top module: `addimm_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the address output is 0 and the fetch strobe is high. Reset also clears all sixteen registers, including the program-counter register.
- R2: The fetch strobe is high for exactly one cycle per instruction. The instruction word on the data input is captured at the end of that cycle, from the address shown on the address output.
- R3: In the third cycle of each instruction, the incrementer adds 4 to the address register. The result is written into both the address register and register 15. An add that names register 15 as its source reads this incremented value.
- R4: The instruction fields are: bits [31:28] opcode (add = 4'b0001), bits [27:24] destination register, bits [23:20] source register, bits [19:15] rotate-right amount, and bits [14:0] an unsigned immediate, zero-extended to 32 bits.
- R5: An add writes the source register plus the rotated immediate into the destination register, with wrap-around modulo 2^32.
- R6: The immediate is rotated right by any amount from 0 to 31 before it reaches the adder.
- R7: An instruction whose opcode is not add changes no register other than the address advance of R3. The next fetch strobe comes 3 cycles after its own strobe.
- R8: An add instruction takes 8 cycles from its fetch strobe to the next fetch strobe.
- R9: An add whose destination is register 15 overrides that instruction's increment. The sum also reloads the address register, so the next fetch is at the sum.
- R10: The address output changes only in an increment cycle or a write-back cycle, or by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Instruction address toward memory |
| mem_rd | output | 1 | High during the fetch step |
| mem_rdata | input | 32 | Instruction word from memory |

## Verification
The block has no result port, so the contents of the register bank can only be seen when a later add targets register 15 and moves the fetch stream. The test program therefore chains its adds so that each interesting sum (the wrap-around, the maximum rotation, a read of register 15) ends up as a jump target, or as an operand of one. The observed fetch addresses then prove the arithmetic. A second run rewrites the first instruction during a mid-run reset, so that a jump through a register shows whether reset really cleared the bank.

// File: rtl/addimm_pkg.sv
package addimm_pkg;

    localparam int unsigned XLEN = 32;

    localparam logic [3:0] OP_ADD = 4'b0001;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_INCR,
        ST_READA,
        ST_READB,
        ST_SHIFT,
        ST_EXEC,
        ST_WRITE
    } step_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  rd;
        logic [3:0]  rn;
        logic [4:0]  rot;
        logic [14:0] imm;
    } instr_t;

    typedef struct packed {
        step_e            step;
        logic [XLEN-1:0]  addr;
        instr_t           ir;
        logic [XLEN-1:0]  bus_a;
        logic [XLEN-1:0]  bus_b;
        logic [XLEN-1:0]  result;
    } core_s;

endpackage

// File: rtl/addimm_adder.sv
module addimm_adder #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] sum_o
);

    logic [DW:0] full_sum;

    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i};
        sum_o    = full_sum[DW-1:0];
    end

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_SUM_WRAP: assert ((sum_o - b_i) == a_i); // R5
        end
    end

endmodule

// File: rtl/addimm_rotator.sv
module addimm_rotator #(
    parameter int unsigned DW = 32,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic [DW-1:0] din_i,
    input  logic [SW-1:0] amt_i,
    output logic [DW-1:0] dout_o
);

    logic [DW-1:0] stage [0:SW];

    assign stage[0] = din_i;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        logic [DW-1:0] rot_val;
        assign rot_val      = {stage[s][STEP-1:0], stage[s][DW-1:STEP]};
        assign stage[s+1]   = amt_i[s] ? rot_val : stage[s];
    end

    assign dout_o = stage[SW];

    always_comb begin
        if (!$isunknown({din_i, amt_i})) begin
            AST_ROT_KEEPS_ONES: assert ($countones(dout_o) == $countones(din_i)); // R6
        end
    end

endmodule

// File: rtl/addimm_regbank.sv
module addimm_regbank #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          pc_we_i,
    input  logic [DW-1:0] pc_data_i,
    output logic [DW-1:0] pc_o
);

    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (pc_we_i) begin
            regs_d[PC_IDX] = pc_data_i;
        end
        // Register write placed last: it takes priority over the increment.
        if (wr_en_i) begin
            regs_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rd_data_o = regs_q[rd_idx_i];
    assign pc_o      = regs_q[PC_IDX];

    AST_WRITE_BEATS_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == PC_IDX) |=> (pc_o == $past(wr_data_i))); // R9

    AST_RESET_CLEARS_PC: assert property (@(posedge clk)
        (!rst_n) |=> (pc_o == '0)); // R1

endmodule

// File: rtl/addimm_core.sv
module addimm_core
    import addimm_pkg::*;
#(
    parameter int unsigned DW      = XLEN,
    parameter int unsigned NREG    = 16,
    parameter int unsigned ADDR_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [31:0]   mem_addr,
    output logic          mem_rd,
    input  logic [31:0]   mem_rdata
);

    localparam int unsigned IW = $clog2(NREG);
    localparam int unsigned SW = $clog2(DW);
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    core_s cq, cd;

    logic [DW-1:0] rf_rdata;
    logic [DW-1:0] pc_val;
    logic [DW-1:0] inc_sum;
    logic [DW-1:0] alu_sum;
    logic [DW-1:0] rot_out;
    logic [DW-1:0] imm_ext;
    logic          rf_we;
    logic          pc_we;
    logic          is_add;

    assign imm_ext = DW'(cq.ir.imm);
    assign is_add  = (cq.ir.op == OP_ADD);

    addimm_adder #(.DW(DW)) u_incr (
        .a_i   (cq.addr),
        .b_i   (DW'(ADDR_STEP)),
        .sum_o (inc_sum)
    );

    addimm_rotator #(.DW(DW)) u_rot (
        .din_i  (cq.bus_b),
        .amt_i  (SW'(cq.ir.rot)),
        .dout_o (rot_out)
    );

    addimm_adder #(.DW(DW)) u_alu (
        .a_i   (cq.bus_a),
        .b_i   (cq.bus_b),
        .sum_o (alu_sum)
    );

    addimm_regbank #(.DW(DW), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (IW'(cq.ir.rn)),
        .rd_data_o (rf_rdata),
        .wr_en_i   (rf_we),
        .wr_idx_i  (IW'(cq.ir.rd)),
        .wr_data_i (cq.result),
        .pc_we_i   (pc_we),
        .pc_data_i (inc_sum),
        .pc_o      (pc_val)
    );

    always_comb begin
        cd    = cq;
        rf_we = 1'b0;
        pc_we = 1'b0;
        unique case (cq.step)
            ST_FETCH: begin
                cd.ir   = instr_t'(mem_rdata);
                cd.step = ST_DECODE;
            end
            ST_DECODE: begin
                cd.step = ST_INCR;
            end
            ST_INCR: begin
                cd.addr = inc_sum;
                pc_we   = 1'b1;
                cd.step = is_add ? ST_READA : ST_FETCH;
            end
            ST_READA: begin
                cd.bus_a = rf_rdata;
                cd.step  = ST_READB;
            end
            ST_READB: begin
                cd.bus_b = imm_ext;
                cd.step  = ST_SHIFT;
            end
            ST_SHIFT: begin
                cd.bus_b = rot_out;
                cd.step  = ST_EXEC;
            end
            ST_EXEC: begin
                cd.result = alu_sum;
                cd.step   = ST_WRITE;
            end
            ST_WRITE: begin
                rf_we = 1'b1;
                if (IW'(cq.ir.rd) == PC_IDX) begin
                    cd.addr = cq.result;
                end
                cd.step = ST_FETCH;
            end
            default: begin
                cd.step = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq <= '{step: ST_FETCH, addr: '0, ir: '0,
                    bus_a: '0, bus_b: '0, result: '0};
        end else begin
            cq <= cd;
        end
    end

    assign mem_addr = 32'(cq.addr);
    assign mem_rd   = (cq.step == ST_FETCH);

    AST_INCR_BY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.step == ST_INCR) |=> (mem_addr == $past(mem_addr) + 32'(ADDR_STEP))); // R3

    AST_PC_MIRRORS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.step == ST_INCR) |=> (pc_val == cq.addr)); // R3

    AST_NONADD_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.step == ST_INCR && !is_add) |=> mem_rd); // R7

    AST_ADD_NO_EARLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.step == ST_INCR && is_add) |=> !mem_rd); // R8

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.step != ST_INCR && cq.step != ST_WRITE) |=> $stable(mem_addr)); // R10

    AST_PC_DEST_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.step == ST_WRITE && cq.ir.rd == 4'd15) |=> (mem_addr == $past(cq.result))); // R9

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R2

endmodule

// File: tb/tb_addimm_core.sv
module tb_addimm_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata;

    logic [31:0] mem [64];

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // fetch log
    logic [31:0] f_addr [$];
    int          f_cyc  [$];

    // behavioural reference state
    int unsigned m_step;
    logic [31:0] m_addr;
    logic [31:0] m_r [16];
    logic [31:0] m_ir, m_a, m_b, m_res;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:2]];

    addimm_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] enc(input int rd, input int rn, input int rot, input int imm);
        return {4'b0001, 4'(rd), 4'(rn), 5'(rot), 15'(imm)};
    endfunction

    function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
        logic [31:0] t;
        t = v;
        for (int k = 0; k < n; k++) t = {t[0], t[31:1]};
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0;
            m_addr = 0;
            for (int i = 0; i < 16; i++) m_r[i] = 0;
        end else begin
            case (m_step)
                0: begin m_ir = mem[m_addr[7:2]]; m_step = 1; end
                1: m_step = 2;
                2: begin
                    m_addr = m_addr + 4;
                    m_r[15] = m_addr;
                    m_step = (m_ir[31:28] == 4'b0001) ? 3 : 0;
                end
                3: begin m_a = m_r[m_ir[23:20]]; m_step = 4; end
                4: begin m_b = {17'd0, m_ir[14:0]}; m_step = 5; end
                5: begin m_b = rotr(m_b, int'(m_ir[19:15])); m_step = 6; end
                6: begin m_res = m_a + m_b; m_step = 7; end
                default: begin
                    m_r[m_ir[27:24]] = m_res;
                    if (m_ir[27:24] == 4'd15) m_addr = m_res;
                    m_step = 0;
                end
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check("R10 address bus vs model", mem_addr, m_addr);
            check("R2 fetch strobe vs model", 32'(mem_rd), 32'(m_step == 0));
            if (mem_rd) begin
                f_addr.push_back(mem_addr);
                f_cyc.push_back(cyc);
            end
        end
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic gaps_check(input int n);
        for (int k = 0; k + 1 < n; k++) begin
            int exp_gap;
            exp_gap = (mem[f_addr[k][7:2]][31:28] == 4'b0001) ? 8 : 3;
            check(exp_gap == 8 ? "R8 add fetch spacing" : "R7 non-add fetch spacing",
                  32'(f_cyc[k+1] - f_cyc[k]), 32'(exp_gap));
        end
    endtask

    initial begin
        logic [31:0] exp1 [18];
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[0]  = enc(1, 0, 0, 5);          // R1 = 5
        mem[1]  = enc(2, 1, 1, 1);          // R2 = 5 + 0x80000000
        mem[2]  = enc(3, 2, 0, 15'h7FFF);   // R3 = 0x80008004
        mem[3]  = 32'hF000_0000;            // non-add
        mem[4]  = enc(4, 15, 0, 0);         // R4 = R15
        mem[5]  = enc(5, 2, 1, 3);          // wraps to 6
        mem[6]  = enc(15, 5, 0, 16'h3A);    // jump 0x40
        mem[16] = enc(15, 4, 0, 16'h30);    // jump R4+0x30
        mem[17] = enc(15, 3, 31, 2);        // jump R3+4

        exp1 = '{32'h0, 32'h4, 32'h8, 32'hC, 32'h10, 32'h14, 32'h18, 32'h40, 32'h44,
                 32'h80008008, 32'h8000800C, 32'h80008010, 32'h80008014, 32'h80008018,
                 32'h40, 32'h80008044, 32'h80008008, 32'h8000800C};

        repeat (3) @(negedge clk);
        check("R1 address in reset", mem_addr, 32'h0);
        check("R1 fetch strobe in reset", 32'(mem_rd), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first fetch at zero", mem_addr, 32'h0);

        repeat (180) @(negedge clk);
        check("R2 fetch count", 32'(f_addr.size() >= 18), 32'h1);
        if (f_addr.size() >= 18) begin
            for (int k = 0; k < 18; k++) begin
                string tag;
                case (k)
                    2:  tag = "R6 R5 rotate by 1 path";
                    8:  tag = "R3 R15 read as source";
                    9:  tag = "R6 rotate by 31";
                    7:  tag = "R5 wrap-around sum";
                    15: tag = "R9 jump via register 15";
                    default: tag = "R4 R9 fetch sequence";
                endcase
                check(tag, f_addr[k], exp1[k]);
            end
            gaps_check(18);
        end

        // mid-run reset, then first word jumps through R5 (must be cleared)
        @(negedge clk);
        rst_n = 1'b0;
        mem[0] = enc(15, 5, 0, 16'h20);
        repeat (2) @(negedge clk);
        check("R1 address after mid-run reset", mem_addr, 32'h0);
        f_addr.delete();
        f_cyc.delete();
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        if (f_addr.size() >= 3) begin
            check("R1 refetch at zero", f_addr[0], 32'h0);
            check("R1 registers cleared by reset", f_addr[1], 32'h20);
            check("R7 non-add advances only", f_addr[2], 32'h24);
            gaps_check(3);
        end else begin
            check("R1 fetches after reset", 32'(f_addr.size()), 32'd3);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule